// File: doc/BRIEF.md
# Word-In Byte-Out Instruction Prefetch Queue

This block sits between the bus side of a processor, which fetches instruction code one 16-bit word at a time, and the instruction decoder, which takes code one byte at a time. It holds up to three words (six bytes) in three word-wide slots. It stores raw fetched bytes only and decodes nothing. A read pointer picks the slot being drained, and a half selector picks the low or high byte of that slot. The low byte of a word is always read before its high byte. After the high byte the pointer moves to the next slot, wrapping after the last one.

Every stored byte carries a ninth service bit that the writer supplies. A set service bit marks a byte that must not reach the decoder, for example the low byte of a fetch that began at an odd address. The read side discards such a byte on its own. Each discard takes one cycle, and the output is not valid in that cycle. Status outputs give the number of usable bytes, the free slots, and the full and empty flags, so the bus side can fetch ahead. A flush input empties the queue when a control transfer happens.

Both data paths use valid/ready. The write side offers a word with `wr_valid`, and the word is taken on a clock edge where `wr_ready` is also high. `wr_ready` is high whenever at least one slot is completely free. A writer facing a low `wr_ready` holds its word and valid. The read side shows a byte with `rd_valid`, and the byte is consumed on an edge where `rd_ready` is also high. While `rd_ready` is low, the byte shown is held unchanged.

Top module: `wbq_prefetch`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1, `q_full`=0, `byte_count`=0, `free_slots`=3, `rd_valid`=0 and `wr_ready`=1.
- R2: A word is stored on a clock edge with `wr_valid` and `wr_ready` both high, and `wr_ready` is high exactly when fewer than three slots are occupied. While all three slots are occupied, an offered word is ignored and `byte_count` does not grow.
- R3: Bytes leave in write order. Each word gives first `wr_data[7:0]` and then `wr_data[15:8]`, and the read slot wraps from the third slot back to the first.
- R4: A byte whose service bit is set is never shown. `wr_skip[0]` goes with the low byte and `wr_skip[1]` with the high byte. Each such byte at the head is dropped in one cycle with `rd_valid` low, and the next byte in order follows.
- R5: With no usable byte at the head, `rd_valid` is 0 and a raised `rd_ready` removes nothing.
- R6: `byte_count` equals the number of stored bytes that are still unread and have a clear service bit, in the range 0 to 6. This holds when a write and a pop happen in the same cycle.
- R7: With `flush` high at a clock edge, the next cycle shows an empty queue with all pointers reset. A write or pop in that same cycle has no effect, and the next word written is read from its low byte.
- R8: `free_slots` equals 3 minus the occupied slots, `q_full` is high exactly when `free_slots` is 0, and `q_empty` is high exactly when `byte_count` is 0.
- R9: While `rd_valid` is high and `rd_ready` is low (and no flush), the next cycle keeps `rd_valid` high with `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of the whole queue |
| wr_valid | input | 1 | A fetched word is offered |
| wr_ready | output | 1 | At least one slot is free; the word is taken |
| wr_data | input | 16 | Fetched word, low byte in bits 7:0 |
| wr_skip | input | 2 | Service bits: bit 0 low byte, bit 1 high byte; 1 = discard |
| rd_valid | output | 1 | `rd_data` holds a usable code byte |
| rd_ready | input | 1 | Decoder takes the byte shown |
| rd_data | output | 8 | Code byte at the head of the queue |
| q_full | output | 1 | All three slots occupied |
| q_empty | output | 1 | No usable byte stored |
| free_slots | output | 2 | Number of completely free slots |
| byte_count | output | 3 | Usable bytes stored, 0 to 6 |

## Verification
Directed runs fill the queue and offer a fourth word, which separates a correct full stall from an overwrite of the oldest slot. They pop an empty queue, which separates an ignored pop from a pointer that moves on its own. They also write words with the low, high or both service bits set, which shows whether skipping and half stepping stay in step. A flush that arrives together with a write and a pop shows whether flush takes priority. Long runs of random writes, pops, skips and rare flushes keep the queue moving through every fill level while pointers wrap, and they catch any `byte_count` error from a write and a pop landing in the same cycle.

// File: rtl/wbq_pkg.sv
`timescale 1ns/1ps
package wbq_pkg;
  // Which byte of the head slot is presented on the read path.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/wbq_store.sv
`timescale 1ns/1ps
// Slot storage: NUM_SLOTS word registers, each lane one byte plus service bit.
module wbq_store
  import wbq_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [2*BYTE_W-1:0]   wr_data,
  input  logic [1:0]            wr_svc,
  input  logic [IDX_W-1:0]      rd_idx,
  input  half_e                 rd_half,
  output logic [BYTE_W-1:0]     rd_byte,
  output logic                  rd_svc
);
  localparam int LANE_W = BYTE_W + 1;
  localparam int SLOT_W = 2 * LANE_W;

  logic [SLOT_W-1:0] slot_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (flush) begin
        slot_q[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        slot_q[s] <= {wr_svc[1], wr_data[2*BYTE_W-1:BYTE_W],
                      wr_svc[0], wr_data[BYTE_W-1:0]};
      end
    end
  end

  logic [SLOT_W-1:0] head_slot;

  always_comb begin
    head_slot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_idx == IDX_W'(s)) head_slot = slot_q[s];
    end
  end

  always_comb begin
    if (rd_half == HALF_HI) begin
      rd_byte = head_slot[LANE_W +: BYTE_W];
      rd_svc  = head_slot[SLOT_W-1];
    end else begin
      rd_byte = head_slot[0 +: BYTE_W];
      rd_svc  = head_slot[LANE_W-1];
    end
  end
endmodule

// File: rtl/wbq_pointers.sv
`timescale 1ns/1ps
// Write slot pointer, read slot pointer, half selector and slot occupancy.
module wbq_pointers
  import wbq_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int IDX_W     = 2,
  parameter int SLOT_CW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_fire,
  input  logic               consume,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output half_e              rd_half,
  output logic [SLOT_CW-1:0] used
);
  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NUM_SLOTS - 1)) ? '0 : i + 1'b1;
  endfunction

  logic word_done;
  assign word_done = consume && (rd_half == HALF_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      rd_half <= HALF_LO;
      used    <= '0;
    end else if (flush) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      rd_half <= HALF_LO;
      used    <= '0;
    end else begin
      if (wr_fire) wr_idx <= bump(wr_idx);
      if (consume) begin
        if (rd_half == HALF_HI) begin
          rd_idx  <= bump(rd_idx);
          rd_half <= HALF_LO;
        end else begin
          rd_half <= HALF_HI;
        end
      end
      used <= used + SLOT_CW'(wr_fire) - SLOT_CW'(word_done);
    end
  end
endmodule

// File: rtl/wbq_level.sv
`timescale 1ns/1ps
// Usable-byte counter and fill status.
module wbq_level #(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_CW   = 2,
  parameter int CNT_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_fire,
  input  logic [1:0]         wr_svc,
  input  logic               pop_fire,
  input  logic [SLOT_CW-1:0] used,
  output logic [CNT_W-1:0]   byte_count,
  output logic [SLOT_CW-1:0] free_slots,
  output logic               q_full,
  output logic               q_empty
);
  logic [CNT_W-1:0] add_n;

  always_comb begin
    add_n = '0;
    if (wr_fire) add_n = CNT_W'(2) - CNT_W'(wr_svc[0]) - CNT_W'(wr_svc[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_count <= '0;
    else if (flush)  byte_count <= '0;
    else             byte_count <= byte_count + add_n - CNT_W'(pop_fire);
  end

  assign free_slots = SLOT_CW'(NUM_SLOTS) - used;
  assign q_full     = (used == SLOT_CW'(NUM_SLOTS));
  assign q_empty    = (byte_count == '0);
endmodule

// File: rtl/wbq_prefetch.sv
`timescale 1ns/1ps
// Word-in byte-out prefetch queue top.
module wbq_prefetch
  import wbq_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int BYTE_W    = 8,
  localparam int WORD_W   = 2 * BYTE_W,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SLOT_CW  = $clog2(NUM_SLOTS + 1),
  localparam int CNT_W    = $clog2(2 * NUM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [1:0]         wr_skip,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               q_full,
  output logic               q_empty,
  output logic [SLOT_CW-1:0] free_slots,
  output logic [CNT_W-1:0]   byte_count
);
  logic [IDX_W-1:0]   wr_idx;
  logic [IDX_W-1:0]   rd_idx;
  half_e              rd_half;
  logic [SLOT_CW-1:0] used;
  logic               head_svc;
  logic               head_present;
  logic               drop;
  logic               pop_fire;
  logic               wr_fire;
  logic               consume;

  assign head_present = (used != '0);
  assign rd_valid     = head_present && !head_svc;
  assign drop         = head_present && head_svc && !flush;
  assign pop_fire     = rd_valid && rd_ready && !flush;
  assign consume      = drop || pop_fire;
  assign wr_ready     = !q_full;
  assign wr_fire      = wr_valid && wr_ready && !flush;

  wbq_store #(.NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_fire),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_svc  (wr_skip),
    .rd_idx  (rd_idx),
    .rd_half (rd_half),
    .rd_byte (rd_data),
    .rd_svc  (head_svc)
  );

  wbq_pointers #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .SLOT_CW(SLOT_CW)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_fire (wr_fire),
    .consume (consume),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx),
    .rd_half (rd_half),
    .used    (used)
  );

  wbq_level #(.NUM_SLOTS(NUM_SLOTS), .SLOT_CW(SLOT_CW), .CNT_W(CNT_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_fire    (wr_fire),
    .wr_svc     (wr_skip),
    .pop_fire   (pop_fire),
    .used       (used),
    .byte_count (byte_count),
    .free_slots (free_slots),
    .q_full     (q_full),
    .q_empty    (q_empty)
  );
endmodule

// File: rtl/wbq_checker.sv
`timescale 1ns/1ps
module wbq_checker #(
  parameter int NUM_SLOTS = 3,
  parameter int BYTE_W    = 8,
  parameter int SLOT_CW   = 2,
  parameter int CNT_W     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [BYTE_W-1:0]  rd_data,
  input logic               q_full,
  input logic               q_empty,
  input logic [SLOT_CW-1:0] free_slots,
  input logic [CNT_W-1:0]   byte_count
);
  a_r2_full_stalls_writer: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !wr_ready);

  a_r2_no_growth_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && wr_valid && !flush) |=> (byte_count <= $past(byte_count)));

  a_r5_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !rd_valid);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CNT_W'(2 * NUM_SLOTS));

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_empty && !q_full && !rd_valid && byte_count == '0 &&
               free_slots == SLOT_CW'(NUM_SLOTS)));

  a_r8_full_matches_free: assert property (@(posedge clk) disable iff (!rst_n)
    q_full == (free_slots == '0));

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_data)));
endmodule

bind wbq_prefetch wbq_checker #(
  .NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W), .SLOT_CW(SLOT_CW), .CNT_W(CNT_W)
) u_wbq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .free_slots (free_slots),
  .byte_count (byte_count)
);

// File: tb/wbq_prefetch_test.sv
`timescale 1ns/1ps
module wbq_prefetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_skip = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        q_full;
  logic        q_empty;
  logic [1:0]  free_slots;
  logic [2:0]  byte_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: word slots in write order.
  logic [15:0] mw [3];
  logic [1:0]  ms [3];
  int          mh = 0;
  int          mn = 0;
  int          mhalf = 0;

  always #2 clk = ~clk;

  wbq_prefetch uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_skip(wr_skip),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .q_full(q_full), .q_empty(q_empty), .free_slots(free_slots), .byte_count(byte_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_count();
    int c = 0;
    for (int k = 0; k < mn; k++) begin
      int idx = (mh + k) % 3;
      for (int b = 0; b < 2; b++) begin
        if (k == 0 && mhalf == 1 && b == 0) continue;
        if (!ms[idx][b]) c++;
      end
    end
    return c;
  endfunction

  function automatic int exp_valid();
    return (mn > 0 && !ms[mh][mhalf]) ? 1 : 0;
  endfunction

  function automatic int exp_byte();
    return mhalf ? int'(mw[mh][15:8]) : int'(mw[mh][7:0]);
  endfunction

  function automatic string valid_tag();
    if (mn == 0) return "R5 rd_valid";
    if (ms[mh][mhalf]) return "R4 rd_valid";
    return "R3 rd_valid";
  endfunction

  task automatic check_all();
    chk(valid_tag(), int'(rd_valid), exp_valid());
    if (exp_valid() == 1) chk("R3 rd_data", int'(rd_data), exp_byte());
    chk("R2 wr_ready", int'(wr_ready), (mn < 3) ? 1 : 0);
    chk("R6 byte_count", int'(byte_count), exp_count());
    chk("R8 free_slots", int'(free_slots), 3 - mn);
    chk("R8 q_full", int'(q_full), (mn == 3) ? 1 : 0);
    chk("R8 q_empty", int'(q_empty), (exp_count() == 0) ? 1 : 0);
  endtask

  // Called at a falling edge: check, drive, advance model, move to next falling edge.
  task automatic step(input bit wv, input logic [15:0] wd, input logic [1:0] ws,
                      input bit rr, input bit fl);
    int n0 = mn;
    int h0 = mh;
    int hf0 = mhalf;
    check_all();
    wr_valid = wv; wr_data = wd; wr_skip = ws; rd_ready = rr; flush = fl;
    if (fl) begin
      mn = 0; mh = 0; mhalf = 0;
    end else begin
      bit cons = (n0 > 0) && (ms[h0][hf0] || rr);
      bit wacc = wv && (n0 < 3);
      if (wacc) begin
        mw[(h0 + n0) % 3] = wd;
        ms[(h0 + n0) % 3] = ws;
      end
      if (cons) begin
        if (hf0 == 1) begin
          mhalf = 0; mh = (h0 + 1) % 3; mn = n0 - 1;
        end else begin
          mhalf = 1;
        end
      end
      if (wacc) mn = mn + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic [7:0] held;
    seed_dummy = $urandom(32'h0000_6502);
    for (int i = 0; i < 3; i++) begin mw[i] = '0; ms[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 q_empty", int'(q_empty), 1);
    chk("R1 q_full", int'(q_full), 0);
    chk("R1 byte_count", int'(byte_count), 0);
    chk("R1 free_slots", int'(free_slots), 3);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);

    // R5: pops on an empty queue
    repeat (3) step(1'b0, 16'h0, 2'b00, 1'b1, 1'b0);

    // R2: fill, then offer a fourth word while full
    step(1'b1, 16'hA1A0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 16'hB1B0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 16'hC1C0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 16'hDEAD, 2'b00, 1'b0, 1'b0);
    chk("R2 full after overfill", int'(q_full), 1);
    chk("R2 count after overfill", int'(byte_count), 6);
    // R9: stalled head holds its byte
    held = rd_data;
    step(1'b0, 16'h0, 2'b00, 1'b0, 1'b0);
    chk("R9 held rd_data", int'(rd_data), int'(held));
    chk("R9 held rd_valid", int'(rd_valid), 1);
    // R3: drain in order, wrapping
    repeat (7) step(1'b0, 16'h0, 2'b00, 1'b1, 1'b0);

    // R4: low byte skipped, high byte skipped, both skipped
    step(1'b1, 16'h1234, 2'b01, 1'b0, 1'b0);
    step(1'b1, 16'h5678, 2'b10, 1'b0, 1'b0);
    step(1'b1, 16'h9ABC, 2'b11, 1'b1, 1'b0);
    repeat (8) step(1'b1, 16'h4321, 2'b00, 1'b1, 1'b0);

    // R7: flush together with a write and a pop
    step(1'b1, 16'h7777, 2'b00, 1'b1, 1'b1);
    chk("R7 count after flush", int'(byte_count), 0);
    chk("R7 empty after flush", int'(q_empty), 1);
    step(1'b1, 16'hBEEF, 2'b00, 1'b0, 1'b0);
    chk("R7 first byte after flush", int'(rd_data), 16'hEF);
    step(1'b0, 16'h0, 2'b00, 1'b1, 1'b0);
    step(1'b0, 16'h0, 2'b00, 1'b1, 1'b0);

    // Random traffic, R6 same-cycle write and pop among it
    for (int i = 0; i < 4000; i++) begin
      bit wv = ($urandom % 100) < 60;
      bit rr = ($urandom % 100) < 55;
      bit fl = ($urandom % 100) < 2;
      logic [1:0] ws = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      step(wv, 16'($urandom), ws, rr, fl);
    end
    check_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule